// File: doc/BRIEF.md
# Password-Gated Index/Data Bus Bridge

This block is an I/O-port slave that gives a host access to a small configuration space through two byte ports: an index port that picks a register and a data port that reads or writes it. The configuration space is locked after reset. A fixed two-byte password must be written to the index port before any register can be used, and a separate code locks it again.

Inside the configuration space, a device-select register chooses which logical device the upper registers belong to. When the bridge device is selected, the host can stage a 32-bit bus address and a 32-bit data word one byte at a time. It can set an access-length code and enable the bridge. Accessing a trigger register then starts one word access on an internal memory bus. A read of the trigger starts a bus read, and the returned word replaces the staged data bytes. A write of the trigger starts a bus write of the staged word. The bus request stays up until the bus signals ready.

Top module: `port_bridge`

## Requirements
- R1: After reset the space is locked, both ports read 0xFF, no bus request is raised, and the index, device-select, enable, length, address and data registers are zero.
- R2: Two index-port writes of 0xA5 in a row unlock the space. Any other index-port write between them restarts the sequence.
- R3: While locked, data-port writes and index-port writes other than 0xA5 change no register, and data-port reads return 0xFF without side effects.
- R4: While unlocked, an index-port write of 0xAA locks the space again and leaves the index unchanged. Staged address and data values survive the lock/unlock cycle.
- R5: While unlocked, any other index-port write sets the index, and a read of the index port returns the current index.
- R6: Index 0x07 is the device select and always reads back. All other registers are reachable only when the select holds 0x0D. Otherwise their writes are ignored and their reads return 0xFF, as do unmapped indexes.
- R7: Index 0x30 is the enable. Only bit 0 is stored, and it reads back as {7'b0, enable}.
- R8: Indexes 0xF0..0xF3 hold the address and 0xF4..0xF7 hold the data word, each with the lowest index as the most significant byte. Each byte reads back what was written.
- R9: Index 0xF8 holds the length code and reads back. The trigger starts a bus access only when the enable is 1, the length is 0x02 and no access is in flight. Otherwise the trigger is ignored.
- R10: A data-port read at index 0xFE returns 0x00 and, when R9 allows, raises a read request at the staged address. The request, address and direction are held until ready. The returned word then reads back at 0xF4..0xF7.
- R11: A data-port write at index 0xFE, when R9 allows, raises a write request carrying the staged address and data word. The word is held until ready.
- R12: A trigger that arrives while a request is pending is ignored and does not change the pending request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| io_wr_i | input | 1 | Port write strobe, one cycle per byte |
| io_rd_i | input | 1 | Port read strobe, one cycle per byte |
| io_sel_data_i | input | 1 | 0 selects the index port, 1 the data port |
| io_wdata_i | input | 8 | Byte written to the selected port |
| io_rdata_o | output | 8 | Byte read from the selected port (combinational) |
| bus_req_o | output | 1 | Internal bus request, held until ready |
| bus_we_o | output | 1 | 1 for a bus write, 0 for a read |
| bus_addr_o | output | 32 | Bus word address |
| bus_wdata_o | output | 32 | Bus write data |
| bus_ready_i | input | 1 | Bus completes the current request |
| bus_rdata_i | input | 32 | Bus read data, valid with ready on a read |

## Verification
A wrong lock state shows up on the next port read. Both ports return 0xFF when the design should answer, or return register contents when it should not. A misdecoded index or wrong device select shows up on the first read-back of a staged byte. A bad staging or trigger decision shows up on the bus lines one cycle after the triggering strobe, as a missing or extra request or a wrong address, direction or word. A bench model updated on every strobe is compared with those lines on every clock. A read response written to the wrong byte lanes is caught when the data bytes are read back.

// File: rtl/port_bridge_pkg.sv
package port_bridge_pkg;
  localparam logic [7:0] PW_BYTE    = 8'hA5;
  localparam logic [7:0] LOCK_BYTE  = 8'hAA;
  localparam logic [7:0] IDX_DEV    = 8'h07;
  localparam logic [7:0] DEV_BRIDGE = 8'h0D;
  localparam logic [7:0] IDX_EN     = 8'h30;
  localparam logic [7:0] IDX_ADDR0  = 8'hF0;
  localparam logic [7:0] IDX_TRIG   = 8'hFE;
  localparam logic [7:0] LEN_WORD   = 8'h02;
  localparam logic [7:0] RD_IDLE    = 8'hFF;
  localparam logic [7:0] RD_TRIG    = 8'h00;
endpackage

// File: rtl/pb_unlock.sv
module pb_unlock
  import port_bridge_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       idx_wr_i,
  input  logic [7:0] wdata_i,
  output logic       unlocked_o
);
  logic armed_q, unlocked_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q    <= 1'b0;
      unlocked_q <= 1'b0;
    end else if (idx_wr_i) begin
      if (unlocked_q) begin
        if (wdata_i == LOCK_BYTE) unlocked_q <= 1'b0;
        armed_q <= 1'b0;
      end else if (wdata_i == PW_BYTE) begin
        if (armed_q) begin
          unlocked_q <= 1'b1;
          armed_q    <= 1'b0;
        end else begin
          armed_q <= 1'b1;
        end
      end else begin
        armed_q <= 1'b0;
      end
    end
  end

  assign unlocked_o = unlocked_q;
endmodule

// File: rtl/pb_cfg_regs.sv
module pb_cfg_regs
  import port_bridge_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          idx_we_i,
  input  logic          dat_we_i,
  input  logic          dat_re_i,
  input  logic [7:0]    wdata_i,
  input  logic          busy_i,
  input  logic          rsp_valid_i,
  input  logic [DW-1:0] rsp_data_i,
  output logic [7:0]    idx_o,
  output logic [7:0]    rdata_o,
  output logic          trig_rd_o,
  output logic          trig_wr_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o
);
  localparam int AB = AW / 8;
  localparam int DB = DW / 8;
  localparam logic [7:0] IDX_DATA0 = IDX_ADDR0 + 8'(AB);
  localparam logic [7:0] IDX_LEN   = IDX_DATA0 + 8'(DB);

  logic [7:0]    idx_q, dev_q, len_q;
  logic          en_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic [AB-1:0] addr_hit;
  logic [DB-1:0] data_hit;
  logic          bridge_sel, trig_ok;

  assign bridge_sel = (dev_q == DEV_BRIDGE);

  for (genvar g = 0; g < AB; g++) begin : g_addr_hit
    assign addr_hit[g] = bridge_sel && (idx_q == IDX_ADDR0 + 8'(g));
  end
  for (genvar g = 0; g < DB; g++) begin : g_data_hit
    assign data_hit[g] = bridge_sel && (idx_q == IDX_DATA0 + 8'(g));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      dev_q <= '0;
      en_q  <= 1'b0;
      len_q <= '0;
    end else begin
      if (idx_we_i) idx_q <= wdata_i;
      if (dat_we_i) begin
        if (idx_q == IDX_DEV) dev_q <= wdata_i;
        else if (bridge_sel && idx_q == IDX_EN) en_q <= wdata_i[0];
        else if (bridge_sel && idx_q == IDX_LEN) len_q <= wdata_i;
      end
    end
  end

  // byte 0 of each window is the most significant
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
    end else if (dat_we_i) begin
      for (int i = 0; i < AB; i++)
        if (addr_hit[i]) addr_q[AW-1-8*i -: 8] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
    end else if (rsp_valid_i) begin
      data_q <= rsp_data_i;
    end else if (dat_we_i) begin
      for (int i = 0; i < DB; i++)
        if (data_hit[i]) data_q[DW-1-8*i -: 8] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = RD_IDLE;
    if (idx_q == IDX_DEV) begin
      rdata_o = dev_q;
    end else if (bridge_sel) begin
      if (idx_q == IDX_EN)        rdata_o = {7'b0, en_q};
      else if (idx_q == IDX_LEN)  rdata_o = len_q;
      else if (idx_q == IDX_TRIG) rdata_o = RD_TRIG;
      for (int i = 0; i < AB; i++)
        if (addr_hit[i]) rdata_o = addr_q[AW-1-8*i -: 8];
      for (int i = 0; i < DB; i++)
        if (data_hit[i]) rdata_o = data_q[DW-1-8*i -: 8];
    end
  end

  assign trig_ok   = bridge_sel && en_q && (len_q == LEN_WORD) && !busy_i && (idx_q == IDX_TRIG);
  assign trig_wr_o = dat_we_i && trig_ok;
  assign trig_rd_o = dat_re_i && trig_ok && !dat_we_i;
  assign idx_o     = idx_q;
  assign addr_o    = addr_q;
  assign data_o    = data_q;
endmodule

// File: rtl/pb_bus_master.sv
module pb_bus_master #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          trig_rd_i,
  input  logic          trig_wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          bus_ready_i,
  input  logic [DW-1:0] bus_rdata_i,
  output logic          bus_req_o,
  output logic          bus_we_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [DW-1:0] bus_wdata_o,
  output logic          busy_o,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_data_o
);
  logic          req_q, we_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q   <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (!req_q && (trig_rd_i || trig_wr_i)) begin
      req_q   <= 1'b1;
      we_q    <= trig_wr_i;
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
    end else if (req_q && bus_ready_i) begin
      req_q <= 1'b0;
    end
  end

  assign bus_req_o   = req_q;
  assign bus_we_o    = we_q;
  assign bus_addr_o  = addr_q;
  assign bus_wdata_o = wdata_q;
  assign busy_o      = req_q;
  assign rsp_valid_o = req_q && bus_ready_i && !we_q;
  assign rsp_data_o  = bus_rdata_i;
endmodule

// File: rtl/port_bridge.sv
module port_bridge
  import port_bridge_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          io_wr_i,
  input  logic          io_rd_i,
  input  logic          io_sel_data_i,
  input  logic [7:0]    io_wdata_i,
  output logic [7:0]    io_rdata_o,
  output logic          bus_req_o,
  output logic          bus_we_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [DW-1:0] bus_wdata_o,
  input  logic          bus_ready_i,
  input  logic [DW-1:0] bus_rdata_i
);
  logic          unlocked, idx_we, dat_we, dat_re;
  logic          trig_rd, trig_wr, busy, rsp_valid;
  logic [7:0]    idx, cfg_rdata;
  logic [AW-1:0] stage_addr;
  logic [DW-1:0] stage_data, rsp_data;

  pb_unlock u_unlock (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .idx_wr_i   (io_wr_i && !io_sel_data_i),
    .wdata_i    (io_wdata_i),
    .unlocked_o (unlocked)
  );

  assign idx_we = io_wr_i && !io_sel_data_i && unlocked && (io_wdata_i != LOCK_BYTE);
  assign dat_we = io_wr_i && io_sel_data_i && unlocked;
  assign dat_re = io_rd_i && io_sel_data_i && unlocked;

  pb_cfg_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .idx_we_i    (idx_we),
    .dat_we_i    (dat_we),
    .dat_re_i    (dat_re),
    .wdata_i     (io_wdata_i),
    .busy_i      (busy),
    .rsp_valid_i (rsp_valid),
    .rsp_data_i  (rsp_data),
    .idx_o       (idx),
    .rdata_o     (cfg_rdata),
    .trig_rd_o   (trig_rd),
    .trig_wr_o   (trig_wr),
    .addr_o      (stage_addr),
    .data_o      (stage_data)
  );

  pb_bus_master #(.AW(AW), .DW(DW)) u_bus (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .trig_rd_i   (trig_rd),
    .trig_wr_i   (trig_wr),
    .addr_i      (stage_addr),
    .wdata_i     (stage_data),
    .bus_ready_i (bus_ready_i),
    .bus_rdata_i (bus_rdata_i),
    .bus_req_o   (bus_req_o),
    .bus_we_o    (bus_we_o),
    .bus_addr_o  (bus_addr_o),
    .bus_wdata_o (bus_wdata_o),
    .busy_o      (busy),
    .rsp_valid_o (rsp_valid),
    .rsp_data_o  (rsp_data)
  );

  always_comb begin
    if (!unlocked)          io_rdata_o = RD_IDLE;
    else if (io_sel_data_i) io_rdata_o = cfg_rdata;
    else                    io_rdata_o = idx;
  end
endmodule

// File: rtl/port_bridge_chk.sv
module port_bridge_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          io_wr_i,
  input logic          io_rd_i,
  input logic          io_sel_data_i,
  input logic [7:0]    io_wdata_i,
  input logic          unlocked_i,
  input logic          bus_req_o,
  input logic          bus_we_o,
  input logic [AW-1:0] bus_addr_o,
  input logic [DW-1:0] bus_wdata_o,
  input logic          bus_ready_i
);
  assert_unlock_cause_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(unlocked_i) |-> $past(io_wr_i && !io_sel_data_i && io_wdata_i == 8'hA5));

  assert_relock_cause_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(unlocked_i) |-> $past(io_wr_i && !io_sel_data_i && io_wdata_i == 8'hAA));

  assert_launch_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_req_o) |-> $past(io_sel_data_i && (io_wr_i || io_rd_i) && unlocked_i));

  assert_req_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_ready_i) |=> (bus_req_o && $stable(bus_addr_o) && $stable(bus_we_o)));

  assert_req_release_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_ready_i) |=> !bus_req_o);

  assert_wdata_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_ready_i && bus_we_o) |=> $stable(bus_wdata_o));
endmodule

bind port_bridge port_bridge_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .io_wr_i       (io_wr_i),
  .io_rd_i       (io_rd_i),
  .io_sel_data_i (io_sel_data_i),
  .io_wdata_i    (io_wdata_i),
  .unlocked_i    (unlocked),
  .bus_req_o     (bus_req_o),
  .bus_we_o      (bus_we_o),
  .bus_addr_o    (bus_addr_o),
  .bus_wdata_o   (bus_wdata_o),
  .bus_ready_i   (bus_ready_i)
);

// File: tb/port_bridge_tb.sv
`timescale 1ns/1ps
module port_bridge_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_wr = 1'b0, io_rd = 1'b0, io_sel = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic        bus_req, bus_we, bus_ready = 1'b0;
  logic [31:0] bus_addr, bus_wdata, bus_rdata = '0;

  int checks = 0, fails = 0;

  // reference model state
  bit         m_unl = 0, m_arm = 0, m_en = 0;
  bit [7:0]   m_idx = 0, m_dev = 0, m_len = 0;
  bit [31:0]  m_addr = 0, m_data = 0;
  bit         m_req = 0, m_we = 0;
  bit [31:0]  m_baddr = 0, m_bwdata = 0;
  bit [31:0]  next_rdata = 0;
  int         lat = 3, cnt = 0;

  always #2.5 clk = ~clk;

  port_bridge dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .io_wr_i(io_wr), .io_rd_i(io_rd), .io_sel_data_i(io_sel),
    .io_wdata_i(io_wdata), .io_rdata_o(io_rdata),
    .bus_req_o(bus_req), .bus_we_o(bus_we), .bus_addr_o(bus_addr),
    .bus_wdata_o(bus_wdata), .bus_ready_i(bus_ready), .bus_rdata_i(bus_rdata)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic bit trig_ok();
    return m_unl && m_dev == 8'h0D && m_idx == 8'hFE && m_en && m_len == 8'h02 && !m_req;
  endfunction

  function automatic bit [7:0] model_read(bit sel);
    if (!m_unl) return 8'hFF;
    if (!sel) return m_idx;
    if (m_idx == 8'h07) return m_dev;
    if (m_dev != 8'h0D) return 8'hFF;
    case (m_idx)
      8'h30: return {7'b0, m_en};
      8'hF0, 8'hF1, 8'hF2, 8'hF3: return m_addr[31 - 8*(m_idx - 8'hF0) -: 8];
      8'hF4, 8'hF5, 8'hF6, 8'hF7: return m_data[31 - 8*(m_idx - 8'hF4) -: 8];
      8'hF8: return m_len;
      8'hFE: return 8'h00;
      default: return 8'hFF;
    endcase
  endfunction

  task automatic launch(bit we);
    m_req = 1; m_we = we; m_baddr = m_addr; m_bwdata = m_data; cnt = 0;
  endtask

  task automatic model_write(bit sel, bit [7:0] v);
    if (!sel) begin
      if (m_unl) begin
        if (v == 8'hAA) begin m_unl = 0; m_arm = 0; end
        else m_idx = v;
      end else if (v == 8'hA5) begin
        if (m_arm) begin m_unl = 1; m_arm = 0; end
        else m_arm = 1;
      end else m_arm = 0;
    end else if (m_unl) begin
      if (m_idx == 8'h07) m_dev = v;
      else if (m_dev == 8'h0D) begin
        case (m_idx)
          8'h30: m_en = v[0];
          8'hF0, 8'hF1, 8'hF2, 8'hF3: m_addr[31 - 8*(m_idx - 8'hF0) -: 8] = v;
          8'hF4, 8'hF5, 8'hF6, 8'hF7: m_data[31 - 8*(m_idx - 8'hF4) -: 8] = v;
          8'hF8: m_len = v;
          8'hFE: if (trig_ok()) launch(1'b1);
          default: ;
        endcase
      end
    end
  endtask

  task automatic io_write(bit sel, bit [7:0] v);
    @(negedge clk);
    model_write(sel, v);
    io_sel = sel; io_wdata = v; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic io_read(bit sel, string tag);
    @(negedge clk);
    io_sel = sel; io_rd = 1'b1;
    #1;
    chk(tag, {24'b0, io_rdata}, {24'b0, model_read(sel)});
    if (sel && trig_ok()) launch(1'b0);
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  task automatic reg_wr(bit [7:0] idx, bit [7:0] v);
    io_write(1'b0, idx);
    io_write(1'b1, v);
  endtask

  task automatic reg_rd(bit [7:0] idx, string tag);
    io_write(1'b0, idx);
    io_read(1'b1, tag);
  endtask

  task automatic wait_idle();
    while (m_req) @(negedge clk);
    @(negedge clk);
  endtask

  // bus responder, also retires the model's request
  always @(negedge clk) begin
    if (bus_ready) bus_ready = 1'b0;
    else if (bus_req) begin
      cnt++;
      if (cnt >= lat) begin
        bus_ready = 1'b1;
        bus_rdata = next_rdata;
        if (!m_we) m_data = next_rdata;
        m_req = 0;
        cnt = 0;
      end
    end
  end

  // per-clock comparison of the bus side (R10, R11, R12)
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      checks++;
      if (bus_req !== m_req || (m_req && (bus_we !== m_we || bus_addr !== m_baddr ||
          (m_we && bus_wdata !== m_bwdata)))) begin
        fails++;
        $display("FAIL R10 R11 R12 bus: actual req=%b we=%b addr=%h wdata=%h expected req=%b we=%b addr=%h wdata=%h",
                 bus_req, bus_we, bus_addr, bus_wdata, m_req, m_we, m_baddr, m_bwdata);
      end
    end
  end

  initial begin
    #(200000 * 5);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 bus_req", {31'b0, bus_req}, 32'h0);
    io_read(1'b0, "R1 index port");
    io_read(1'b1, "R1 data port");
    // R3 locked accesses ignored
    io_write(1'b1, 8'h33);
    io_write(1'b0, 8'h07);
    io_read(1'b1, "R3 locked data read");
    // R2 broken sequence
    io_write(1'b0, 8'hA5);
    io_write(1'b0, 8'h11);
    io_write(1'b0, 8'hA5);
    io_read(1'b0, "R2 still locked");
    io_write(1'b0, 8'hA5);
    io_read(1'b0, "R2 unlocked, R5 index unchanged");
    // R5 index read-back
    io_write(1'b0, 8'h42);
    io_read(1'b0, "R5 index readback");
    // R6 device select gating
    reg_wr(8'h07, 8'h05);
    reg_wr(8'hF0, 8'h99);
    reg_rd(8'h07, "R6 select readback");
    reg_rd(8'hF0, "R6 other device reads FF");
    reg_wr(8'h07, 8'h0D);
    reg_rd(8'hF0, "R6 ignored write");
    reg_rd(8'h55, "R6 unmapped index");
    // R8 staging
    reg_wr(8'hF0, 8'h12); reg_wr(8'hF1, 8'h34); reg_wr(8'hF2, 8'h56); reg_wr(8'hF3, 8'h78);
    reg_wr(8'hF4, 8'hDE); reg_wr(8'hF5, 8'hAD); reg_wr(8'hF6, 8'hBE); reg_wr(8'hF7, 8'hEF);
    reg_rd(8'hF0, "R8 addr msb");
    reg_rd(8'hF3, "R8 addr lsb");
    reg_rd(8'hF5, "R8 data byte");
    // R9 gating: enable off
    reg_wr(8'hF8, 8'h02);
    reg_wr(8'hFE, 8'h00);
    chk("R9 no launch disabled", {31'b0, bus_req}, 32'h0);
    // R7 enable bit
    reg_wr(8'h30, 8'h03);
    reg_rd(8'h30, "R7 enable readback");
    // R9 wrong length
    reg_wr(8'hF8, 8'h01);
    reg_wr(8'hFE, 8'h00);
    chk("R9 no launch bad length", {31'b0, bus_req}, 32'h0);
    reg_wr(8'hF8, 8'h02);
    reg_rd(8'hF8, "R9 length readback");
    // R11 write launch, R12 trigger while busy
    reg_wr(8'hFE, 8'h00);
    chk("R11 write launched", {31'b0, bus_req}, 32'h1);
    io_read(1'b1, "R12 trigger read while busy");
    wait_idle();
    // R10 read launch
    next_rdata = 32'hCAFEF00D;
    io_read(1'b1, "R10 trigger read returns 00");
    chk("R10 read launched", {bus_req, bus_we}, 32'h2);
    wait_idle();
    reg_rd(8'hF4, "R10 result msb");
    reg_rd(8'hF7, "R10 result lsb");
    // R4 relock and retention
    io_write(1'b0, 8'hAA);
    io_read(1'b0, "R4 relocked index");
    io_read(1'b1, "R4 relocked data");
    io_write(1'b1, 8'h77);
    io_write(1'b0, 8'hA5);
    io_write(1'b0, 8'hA5);
    io_read(1'b0, "R4 index retained");
    reg_rd(8'hF0, "R4 address retained");
    reg_rd(8'hF6, "R4 data retained");
    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule